// File: doc/BRIEF.md
# Bit-Reversed Write Address Generator

This block forms the effective address for a data write and, when its conditions are met, steps the pointer in bit-reversed order instead of linear order. Radix-2 FFT stages produce results in an order whose index bits are mirrored. Walking the store pointer with a reverse-carry step puts each result straight into natural order as it is written. Software sets a pivot equal to half the buffer length in words. It places the buffer on a start address whose low bits are zero, and it uses pre-increment or post-increment writes through any pointer register except the stack pointer.

Each request carries the pointer value, the number of the pointer register, the addressing mode, a write flag and a word/byte flag. One clock later the block returns the effective address, the new pointer value and a strobe that says whether the pointer is written back. When reversal does not apply, the same outputs follow ordinary linear addressing. A single configuration word holds the enable bit and the pivot.

Top module: `brev_wagu`

## Requirements
- R1: After reset the enable bit and the pivot are zero. `out_valid`, `out_wb_en`, `out_brev`, `out_ea` and `out_wb_data` are all zero.
- R2: A write on the configuration port loads `cfg_wdata[15]` as the enable bit and `cfg_wdata[14:0]` as the pivot. A request presented in the same cycle as the configuration write still sees the old setting. Requests from the next cycle onward see the new one.
- R3: Reversal (`out_brev`=1) applies only when all of these hold: enable set, `req_sel` not equal to 15, mode post-increment (1) or pre-increment (2), `req_write`=1 and `req_word`=1. Any other request gets linear addressing.
- R4: The reversed step adds the byte modifier `{pivot,0}` to the pointer with the carry moving from the MSB toward the LSB. Any carry leaving bit 1 downward is dropped. Pointer bits above the highest set bit of the modifier are unchanged.
- R5: With reversal in post-increment mode, `out_ea` is the old pointer with bit 0 cleared, and `out_wb_data` is the reverse-carry sum.
- R6: With reversal in pre-increment mode, `out_ea` and `out_wb_data` are both the reverse-carry sum. The normal step of 1 or 2 is not added.
- R7: Every address produced under reversal has bit 0 equal to zero.
- R8: Linear addressing uses a step of 2 for word accesses and 1 for byte accesses. The mode codes are: 0 plain indirect (EA = pointer, no write-back), 1 post-increment, 2 pre-increment, 3 post-decrement, 4 pre-decrement. Codes 5 to 7 behave as code 0. Post modes address with the old pointer and pre modes with the new one, and modes 1 to 4 write the new pointer back.
- R9: Results appear exactly one clock after the request. `out_valid` follows `req_valid` with that delay, and `out_wb_en` is never high without `out_valid`.
- R10: With the pivot equal to half the buffer length in words and an aligned start address, a chain of post-increment writes visits the buffer in bit-reversed index order. The pointer returns to the start after a full pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Enable in bit 15, pivot in bits 14:0 |
| req_valid | input | 1 | Request present |
| req_ptr | input | 16 | Current pointer value (byte address) |
| req_sel | input | 4 | Number of the pointer register |
| req_mode | input | 3 | Addressing mode code |
| req_write | input | 1 | 1 for a data write, 0 for a read |
| req_word | input | 1 | 1 for word size, 0 for byte |
| out_valid | output | 1 | Result present |
| out_ea | output | 16 | Effective address |
| out_wb_data | output | 16 | New pointer value |
| out_wb_en | output | 1 | Pointer write-back strobe |
| out_brev | output | 1 | Result produced by the reversed step |

## Verification
The bench walks a 16-word buffer through a full reversed pass and checks each address against mirrored 4-bit indices. An adder whose carry ran upward, or that kept the carry below bit 1, would leave that order or fail to wrap to the start. Each qualifying condition is broken one at a time: stack register, read, byte, decrement mode and enable off. A qualifier that ignored any of them would raise `out_brev` or add the pivot where a linear step belongs. The bench also checks pre-increment against post-increment, to catch a design that writes with the wrong pointer or still adds the normal step. It checks a pointer with high bits set, to catch a design that disturbs bits above the buffer field. Finally it sends a request in the same cycle as a configuration write, to catch a setting that takes effect one cycle too early.

// File: rtl/brev_pkg.sv
package brev_pkg;

   typedef enum logic [2:0] {
      AM_IND     = 3'd0,
      AM_POSTINC = 3'd1,
      AM_PREINC  = 3'd2,
      AM_POSTDEC = 3'd3,
      AM_PREDEC  = 3'd4
   } amode_e;

   localparam int MODE_W = 3;

   function automatic amode_e decode_mode(input logic [MODE_W-1:0] code);
      amode_e m;
      case (code)
         3'd1:    m = AM_POSTINC;
         3'd2:    m = AM_PREINC;
         3'd3:    m = AM_POSTDEC;
         3'd4:    m = AM_PREDEC;
         default: m = AM_IND;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/brev_cfg_reg.sv
module brev_cfg_reg #(
   parameter int PIV_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [PIV_W:0]   wdata,
   output logic             en,
   output logic [PIV_W-1:0] pivot
);

   if (PIV_W < 1) begin : g_bad_piv
      $error("brev_cfg_reg: PIV_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en    <= 1'b0;
         pivot <= '0;
      end else if (we) begin
         en    <= wdata[PIV_W];
         pivot <= wdata[PIV_W-1:0];
      end
   end

   // R2: a configuration write is visible on the next cycle
   p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (en == $past(wdata[PIV_W])) && (pivot == $past(wdata[PIV_W-1:0])));

   p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(en) && $stable(pivot));

endmodule

// File: rtl/brev_qualify.sv
module brev_qualify
   import brev_pkg::*;
#(
   parameter int SEL_W     = 4,
   parameter int STACK_SEL = 15
) (
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   input  amode_e           mode,
   input  logic             is_write,
   input  logic             is_word,
   output logic             active,
   output logic             pre_mode
);

   localparam logic [SEL_W-1:0] STACK_CODE = SEL_W'(STACK_SEL);

   if (STACK_SEL >= (1 << SEL_W)) begin : g_bad_stack
      $error("brev_qualify: STACK_SEL does not fit in SEL_W bits");
   end

   logic inc_mode;
   logic not_stack;

   always_comb begin
      inc_mode  = (mode == AM_POSTINC) || (mode == AM_PREINC);
      not_stack = (sel != STACK_CODE);
      active    = en && not_stack && inc_mode && is_write && is_word;
      pre_mode  = (mode == AM_PREINC);
   end

   // R3: the stack pointer never qualifies
   always_comb begin
      if (sel == STACK_CODE) begin
         p_stack_excluded_r3: assert (!active);
      end
   end

endmodule

// File: rtl/brev_rcadd.sv
module brev_rcadd #(
   parameter int AW    = 16,
   parameter int STYLE = 0
) (
   input  logic [AW-1:0] a,
   input  logic [AW-1:0] b,
   output logic [AW-1:0] sum
);

   if (STYLE != 0 && STYLE != 1) begin : g_bad_style
      $error("brev_rcadd: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_ripple_down
      // carry moves from the top bit toward bit 0
      always_comb begin
         logic cy;
         cy  = 1'b0;
         sum = '0;
         for (int i = AW - 1; i >= 0; i--) begin
            sum[i] = a[i] ^ b[i] ^ cy;
            cy     = (a[i] & b[i]) | (a[i] & cy) | (b[i] & cy);
         end
      end
   end else begin : g_mirror_add
      // mirror both operands, add normally, mirror the result back
      logic [AW-1:0] ra;
      logic [AW-1:0] rb;
      logic [AW-1:0] rs;
      for (genvar g = 0; g < AW; g++) begin : g_mir
         assign ra[g]        = a[AW-1-g];
         assign rb[g]        = b[AW-1-g];
         assign sum[AW-1-g]  = rs[g];
      end
      assign rs = ra + rb;
   end

endmodule

// File: rtl/brev_lin_agu.sv
module brev_lin_agu
   import brev_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic [AW-1:0] ptr,
   input  amode_e        mode,
   input  logic          is_word,
   output logic [AW-1:0] ea,
   output logic [AW-1:0] wb,
   output logic          wbe
);

   localparam logic [AW-1:0] STEP_W = AW'(2);
   localparam logic [AW-1:0] STEP_B = AW'(1);

   logic [AW-1:0] step;
   logic [AW-1:0] up;
   logic [AW-1:0] dn;

   always_comb begin
      step = is_word ? STEP_W : STEP_B;
      up   = ptr + step;
      dn   = ptr - step;
      case (mode)
         AM_POSTINC: begin ea = ptr; wb = up; wbe = 1'b1; end
         AM_PREINC:  begin ea = up;  wb = up; wbe = 1'b1; end
         AM_POSTDEC: begin ea = ptr; wb = dn; wbe = 1'b1; end
         AM_PREDEC:  begin ea = dn;  wb = dn; wbe = 1'b1; end
         default:    begin ea = ptr; wb = ptr; wbe = 1'b0; end
      endcase
   end

endmodule

// File: rtl/brev_wagu.sv
module brev_wagu
   import brev_pkg::*;
#(
   parameter int AW        = 16,
   parameter int PIV_W     = 15,
   parameter int SEL_W     = 4,
   parameter int STACK_SEL = 15,
   parameter int RC_STYLE  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [PIV_W:0]   cfg_wdata,
   input  logic             req_valid,
   input  logic [AW-1:0]    req_ptr,
   input  logic [SEL_W-1:0] req_sel,
   input  logic [2:0]       req_mode,
   input  logic             req_write,
   input  logic             req_word,
   output logic             out_valid,
   output logic [AW-1:0]    out_ea,
   output logic [AW-1:0]    out_wb_data,
   output logic             out_wb_en,
   output logic             out_brev
);

   localparam int MOD_W = PIV_W + 1;

   if (AW < MOD_W) begin : g_bad_aw
      $error("brev_wagu: AW must hold the scaled pivot");
   end

   logic             cfg_en;
   logic [PIV_W-1:0] cfg_pivot;
   amode_e           mode;
   logic             act;
   logic             pre;
   logic [AW-1:0]    modifier;
   logic [AW-1:0]    ptr_al;
   logic [AW-1:0]    rc_sum;
   logic [AW-1:0]    rc_al;
   logic [AW-1:0]    lin_ea;
   logic [AW-1:0]    lin_wb;
   logic             lin_wbe;
   logic [AW-1:0]    nxt_ea;
   logic [AW-1:0]    nxt_wb;
   logic             nxt_wbe;

   assign mode = decode_mode(req_mode);

   brev_cfg_reg #(.PIV_W(PIV_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .en    (cfg_en),
      .pivot (cfg_pivot)
   );

   brev_qualify #(.SEL_W(SEL_W), .STACK_SEL(STACK_SEL)) u_qual (
      .en       (cfg_en),
      .sel      (req_sel),
      .mode     (mode),
      .is_write (req_write),
      .is_word  (req_word),
      .active   (act),
      .pre_mode (pre)
   );

   // pivot is a word count; scale it to a byte modifier
   assign modifier = AW'({cfg_pivot, 1'b0});
   assign ptr_al   = {req_ptr[AW-1:1], 1'b0};

   brev_rcadd #(.AW(AW), .STYLE(RC_STYLE)) u_rc (
      .a   (ptr_al),
      .b   (modifier),
      .sum (rc_sum)
   );

   assign rc_al = {rc_sum[AW-1:1], 1'b0};

   brev_lin_agu #(.AW(AW)) u_lin (
      .ptr     (req_ptr),
      .mode    (mode),
      .is_word (req_word),
      .ea      (lin_ea),
      .wb      (lin_wb),
      .wbe     (lin_wbe)
   );

   always_comb begin
      if (act) begin
         nxt_ea  = pre ? rc_al : ptr_al;
         nxt_wb  = rc_al;
         nxt_wbe = 1'b1;
      end else begin
         nxt_ea  = lin_ea;
         nxt_wb  = lin_wb;
         nxt_wbe = lin_wbe;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_ea      <= '0;
         out_wb_data <= '0;
         out_wb_en   <= 1'b0;
         out_brev    <= 1'b0;
      end else begin
         out_valid   <= req_valid;
         out_ea      <= nxt_ea;
         out_wb_data <= nxt_wb;
         out_wb_en   <= req_valid && nxt_wbe;
         out_brev    <= req_valid && act;
      end
   end

   // R9: one-cycle latency and strobe qualification
   p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);
   p_idle_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid && !out_wb_en);

   // R7: reversed addresses are word aligned
   p_ea_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_brev |-> (out_ea[0] == 1'b0) && (out_wb_data[0] == 1'b0));

   // R3: stack pointer requests never reverse
   p_no_stack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_sel == SEL_W'(STACK_SEL)) |=> !out_brev);

   // R6: pre-increment writes with the new pointer
   p_pre_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_mode == 3'd2) |=> out_brev -> (out_ea == out_wb_data));

   // R5: post-increment writes with the old aligned pointer
   p_post_old_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_mode == 3'd1) |=>
         out_brev -> (out_ea == {$past(req_ptr[AW-1:1]), 1'b0}));

endmodule

// File: tb/sim_brev_wagu.sv
module sim_brev_wagu;

   typedef struct {
      logic [15:0] ea;
      logic [15:0] wb;
      logic        wbe;
      logic        brev;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [15:0] req_ptr = '0;
   logic [3:0]  req_sel = '0;
   logic [2:0]  req_mode = '0;
   logic        req_write = 1'b0;
   logic        req_word = 1'b0;
   logic        out_valid;
   logic [15:0] out_ea;
   logic [15:0] out_wb_data;
   logic        out_wb_en;
   logic        out_brev;

   int total = 0;
   int fails = 0;
   exp_t sb[$];
   logic        m_en = 1'b0;
   logic [14:0] m_piv = '0;

   always #10 clk = ~clk;

   brev_wagu u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_ptr(req_ptr), .req_sel(req_sel),
      .req_mode(req_mode), .req_write(req_write), .req_word(req_word),
      .out_valid(out_valid), .out_ea(out_ea), .out_wb_data(out_wb_data),
      .out_wb_en(out_wb_en), .out_brev(out_brev)
   );

   function automatic logic [15:0] mirror16(input logic [15:0] v);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = v[15-i];
      return r;
   endfunction

   function automatic logic [3:0] mirror4(input logic [3:0] v);
      return {v[0], v[1], v[2], v[3]};
   endfunction

   function automatic exp_t model(input logic [15:0] p, input logic [3:0] s,
                                  input logic [2:0] m, input logic w,
                                  input logic wd, input string tag);
      exp_t e;
      logic [15:0] st, pa, mo, rs;
      e.tag = tag;
      st = wd ? 16'd2 : 16'd1;
      pa = {p[15:1], 1'b0};
      mo = {m_piv, 1'b0};
      rs = mirror16(mirror16(pa) + mirror16(mo));
      rs[0] = 1'b0;
      e.brev = m_en && (s != 4'd15) && (m == 3'd1 || m == 3'd2) && w && wd;
      if (e.brev) begin
         e.ea = (m == 3'd2) ? rs : pa; e.wb = rs; e.wbe = 1'b1;
      end else begin
         case (m)
            3'd1: begin e.ea = p;      e.wb = p + st; e.wbe = 1'b1; end
            3'd2: begin e.ea = p + st; e.wb = p + st; e.wbe = 1'b1; end
            3'd3: begin e.ea = p;      e.wb = p - st; e.wbe = 1'b1; end
            3'd4: begin e.ea = p - st; e.wb = p - st; e.wbe = 1'b1; end
            default: begin e.ea = p; e.wb = p; e.wbe = 1'b0; end
         endcase
      end
      return e;
   endfunction

   task automatic check(input bit ok, input string tag, input string act, input string exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %s expected %s", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = d; req_valid = 1'b0;
      @(negedge clk);
      cfg_we = 1'b0;
      m_en = d[15]; m_piv = d[14:0];
   endtask

   task automatic send(input logic [15:0] p, input logic [3:0] s, input logic [2:0] m,
                       input logic w, input logic wd, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_ptr = p; req_sel = s; req_mode = m;
      req_write = w; req_word = wd;
      sb.push_back(model(p, s, m, w, wd, tag));
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor: pops the oldest expected item when a result appears
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R9 unexpected result", "valid", "idle");
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(out_ea == e.ea && out_brev == e.brev && out_wb_en == e.wbe &&
                  (!e.wbe || out_wb_data == e.wb), e.tag,
                  $sformatf("ea=%h wb=%h wbe=%0d brev=%0d", out_ea, out_wb_data, out_wb_en, out_brev),
                  $sformatf("ea=%h wb=%h wbe=%0d brev=%0d", e.ea, e.wb, e.wbe, e.brev));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "watchdog", "timeout", "finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!out_valid && !out_wb_en && !out_brev && out_ea == 0 && out_wb_data == 0,
            "R1 reset outputs", $sformatf("v=%0d ea=%h", out_valid, out_ea), "all zero");
      rst_n = 1'b1;
      // R1: reversal disabled after reset
      send(16'h0200, 4'd3, 3'd1, 1'b1, 1'b1, "R1 disabled after reset");
      // R8: linear modes, word and byte
      send(16'h1000, 4'd2, 3'd1, 1'b1, 1'b1, "R8 post-inc word");
      send(16'h1001, 4'd2, 3'd2, 1'b1, 1'b0, "R8 pre-inc byte");
      send(16'h1000, 4'd2, 3'd3, 1'b0, 1'b1, "R8 post-dec word");
      send(16'h1000, 4'd2, 3'd4, 1'b1, 1'b0, "R8 pre-dec byte");
      send(16'h1234, 4'd2, 3'd0, 1'b1, 1'b1, "R8 plain indirect");
      send(16'h1234, 4'd2, 3'd6, 1'b1, 1'b1, "R8 unused code as indirect");
      // R2: same-cycle request sees old setting
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = 16'h8008;
      req_valid = 1'b1; req_ptr = 16'h0200; req_sel = 4'd1; req_mode = 3'd1;
      req_write = 1'b1; req_word = 1'b1;
      sb.push_back(model(16'h0200, 4'd1, 3'd1, 1'b1, 1'b1, "R2 same-cycle old config"));
      @(negedge clk);
      cfg_we = 1'b0; m_en = 1'b1; m_piv = 15'd8;
      req_valid = 1'b1;
      sb.push_back(model(16'h0200, 4'd1, 3'd1, 1'b1, 1'b1, "R2 next-cycle new config"));
      @(negedge clk);
      req_valid = 1'b0;
      // R10, R5: full bit-reversed pass over a 16-word buffer
      for (int i = 0; i < 16; i++) begin
         exp_t e;
         logic [15:0] cur, nxt;
         cur = 16'h0200 + {11'd0, mirror4(4'(i)), 1'b0};
         nxt = 16'h0200 + {11'd0, mirror4(4'(i + 1)), 1'b0};
         @(negedge clk);
         req_valid = 1'b1; req_ptr = cur; req_sel = 4'd5; req_mode = 3'd1;
         req_write = 1'b1; req_word = 1'b1;
         e.ea = cur; e.wb = nxt; e.wbe = 1'b1; e.brev = 1'b1;
         e.tag = $sformatf("R10 R5 reversed pass step %0d", i);
         sb.push_back(e);
      end
      @(negedge clk);
      req_valid = 1'b0;
      // R3: each broken condition forces linear addressing
      send(16'h0204, 4'd15, 3'd1, 1'b1, 1'b1, "R3 stack register");
      send(16'h0204, 4'd5, 3'd1, 1'b0, 1'b1, "R3 read");
      send(16'h0204, 4'd5, 3'd2, 1'b1, 1'b0, "R3 byte");
      send(16'h0204, 4'd5, 3'd3, 1'b1, 1'b1, "R3 decrement mode");
      send(16'h0204, 4'd14, 3'd2, 1'b1, 1'b1, "R3 register 14 qualifies");
      // R6: pre-increment, no normal step added
      send(16'h0210, 4'd5, 3'd2, 1'b1, 1'b1, "R6 pre-inc reversed");
      // R7: odd pointer gets aligned
      send(16'h0213, 4'd5, 3'd1, 1'b1, 1'b1, "R7 odd pointer aligned");
      // R4: high bits pass through, carry below bit 1 dropped
      cfg_write(16'h8004);
      send(16'hF3F8, 4'd0, 3'd2, 1'b1, 1'b1, "R4 high bits kept");
      send(16'hF3FE, 4'd0, 3'd1, 1'b1, 1'b1, "R4 carry out dropped");
      // R4: explicit value check of one reversed step
      begin
         exp_t e;
         @(negedge clk);
         req_valid = 1'b1; req_ptr = 16'hF3F8; req_sel = 4'd0; req_mode = 3'd1;
         req_write = 1'b1; req_word = 1'b1;
         e.ea = 16'hF3F8; e.wb = 16'hF3F4; e.wbe = 1'b1; e.brev = 1'b1;
         e.tag = "R4 known sum";
         sb.push_back(e);
         @(negedge clk);
         req_valid = 1'b0;
      end
      // R2: disable stops reversal
      cfg_write(16'h0008);
      send(16'h0200, 4'd1, 3'd1, 1'b1, 1'b1, "R2 enable cleared");
      repeat (4) @(negedge clk);
      check(sb.size() == 0, "R9 all results returned", $sformatf("%0d left", sb.size()), "0 left");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule